// File: doc/BRIEF.md
# Inclusive L2 Snoop Filter

This block keeps a larger second-level cache inclusive of a private first-level cache that uses the same line size. Because of this, only the L2 needs to watch the external coherence bus. For every L2 line it holds two bits:

- A presence flag, which says the L1 also holds the line.
- A stale flag, which says the L1 has written the line. The newest data is then in the L1 and not in the L2.

The L1 reports three kinds of notification: fills, evictions and write hits. The L2 side presents three kinds of event: external snoops, external read-exclusive snoops and its own evictions. The block decides whether the L1 has to act on each event.

When an event does not concern the L1, it completes at once and sends nothing to the L1. Otherwise the block issues a single-cycle request to the L1, which is either invalidate or write back. It then holds the event's completion until the L1 acknowledges. Line identifiers are the concatenation of L2 set and way. The data arrays and the bus protocol state machine live elsewhere.

Top module: `inclusive_snoop_filter`

## Requirements
- R1: After reset every presence and stale flag is clear, `ev_ready_o` is 1, and `l1_req_o` and `done_o` are 0.
- R2: An L1 notification with `l1_op_i` = 1 (fill) sets the line's presence flag and clears its stale flag. `l1_op_i` = 2 (evict) clears both flags. `l1_op_i` = 0 does nothing.
- R3: `l1_op_i` = 3 (write hit) sets the stale flag only if the presence flag is set. On a line without the presence flag it is ignored.
- R4: An event accepted with `ev_kind_i` = 1 (external read-exclusive) or 2 (L2 eviction) on a line whose presence flag is set raises `l1_req_o` in the cycle after acceptance. The request carries `l1_req_inv_o` = 1 and `l1_req_wb_o` equal to the stale flag. After completion both flags of the line are clear.
- R5: An event with `ev_kind_i` = 0 (external read) on a line with both flags set requests `l1_req_wb_o` = 1 with `l1_req_inv_o` = 0. Completion clears the stale flag and keeps the presence flag.
- R6: An event that needs no L1 action completes in the cycle after acceptance: `done_o` = 1, `done_l1_o` = 0, `done_wb_o` = 0, and `l1_req_o` stays 0. This covers any kind with the presence flag clear, and kind 0 with the stale flag clear.
- R7: `l1_req_o` lasts one cycle and `ev_ready_o` is 0 while an event is in flight. `done_o` rises in the cycle after `l1_ack_i` is sampled and not before. `ev_ready_o` returns the cycle after `done_o`.
- R8: On completion of an event that issued a request, `done_l1_o` = 1 and `done_wb_o` equals the request's write-back flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1_op_i | input | 2 | L1 notification: 0 none, 1 fill, 2 evict, 3 write hit |
| l1_line_i | input | LW | Line addressed by the L1 notification |
| ev_valid_i | input | 1 | Snoop or L2 eviction event present |
| ev_kind_i | input | 2 | 0 external read, 1 external read-exclusive, 2 L2 eviction |
| ev_line_i | input | LW | Line addressed by the event |
| ev_ready_o | output | 1 | Block is idle and accepts an event |
| l1_req_o | output | 1 | Single-cycle request to the L1 |
| l1_req_line_o | output | LW | Line of the L1 request |
| l1_req_inv_o | output | 1 | Request invalidates the L1 copy |
| l1_req_wb_o | output | 1 | Request pulls modified data back from the L1 |
| l1_ack_i | input | 1 | L1 acknowledges the request |
| done_o | output | 1 | Event completed, L2 may finish its response |
| done_l1_o | output | 1 | Completed event involved the L1 |
| done_wb_o | output | 1 | Completed event pulled data back from the L1 |

## Verification
The assertions check the handshake shape on every cycle. A request lasts one cycle and only follows an acceptance. Readiness stays low while busy. A completion that involved the L1 follows an acknowledge. An immediate completion never claims L1 involvement.

Whether a flag was set, kept or cleared is only visible through the scenarios. In each one the bench builds a flag state with notifications, applies an event under several acknowledge delays, and then probes the line with a read-exclusive event. That probe exposes the remaining flags through the request it does or does not produce.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    L1_NONE  = 2'd0,
    L1_FILL  = 2'd1,
    L1_EVICT = 2'd2,
    L1_WRHIT = 2'd3
  } l1_op_e;

  typedef enum logic [1:0] {
    EV_SNP_RD  = 2'd0,
    EV_SNP_RDX = 2'd1,
    EV_L2_EVCT = 2'd2,
    EV_RSVD    = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } seq_st_e;
endpackage

// File: rtl/sf_line_bits.sv
module sf_line_bits
  import sf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   op_hit_i,
  input  l1_op_e op_i,
  input  logic   upd_hit_i,
  input  logic   clr_incl_i,
  output logic   incl_o,
  output logic   stale_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      incl_o  <= 1'b0;
      stale_o <= 1'b0;
    end else if (upd_hit_i) begin
      // completion of an in-flight event wins over a same-cycle notification
      if (clr_incl_i) incl_o <= 1'b0;
      stale_o <= 1'b0;
    end else if (op_hit_i) begin
      unique case (op_i)
        L1_FILL: begin
          incl_o  <= 1'b1;
          stale_o <= 1'b0;
        end
        L1_EVICT: begin
          incl_o  <= 1'b0;
          stale_o <= 1'b0;
        end
        L1_WRHIT: stale_o <= stale_o | incl_o;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sf_state_array.sv
module sf_state_array
  import sf_pkg::*;
#(
  parameter int unsigned LW    = 3,
  localparam int unsigned LINES = 1 << LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  l1_op_e        op_i,
  input  logic [LW-1:0] op_line_i,
  input  logic          upd_en_i,
  input  logic [LW-1:0] upd_line_i,
  input  logic          upd_clr_incl_i,
  input  logic [LW-1:0] rd_line_i,
  output logic          rd_incl_o,
  output logic          rd_stale_o
);
  logic [LINES-1:0] incl_v;
  logic [LINES-1:0] stale_v;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic op_hit, upd_hit;
    assign op_hit  = (op_i != L1_NONE) && (op_line_i == LW'(g));
    assign upd_hit = upd_en_i && (upd_line_i == LW'(g));
    sf_line_bits u_bits (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .op_hit_i   (op_hit),
      .op_i       (op_i),
      .upd_hit_i  (upd_hit),
      .clr_incl_i (upd_clr_incl_i),
      .incl_o     (incl_v[g]),
      .stale_o    (stale_v[g])
    );
  end

  assign rd_incl_o  = incl_v[rd_line_i];
  assign rd_stale_o = stale_v[rd_line_i];
endmodule

// File: rtl/sf_seq.sv
module sf_seq
  import sf_pkg::*;
#(
  parameter int unsigned LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_valid_i,
  input  ev_kind_e      ev_kind_i,
  input  logic [LW-1:0] ev_line_i,
  input  logic          rd_incl_i,
  input  logic          rd_stale_i,
  input  logic          ack_i,
  output logic          ready_o,
  output logic          req_o,
  output logic [LW-1:0] req_line_o,
  output logic          req_inv_o,
  output logic          req_wb_o,
  output logic          done_o,
  output logic          done_l1_o,
  output logic          done_wb_o,
  output logic          upd_en_o,
  output logic [LW-1:0] upd_line_o,
  output logic          upd_clr_incl_o
);
  seq_st_e       st_q;
  logic [LW-1:0] line_q;
  logic          need_q, inv_q, wb_q;
  logic          inv_now, need_now, wb_now;

  // plain reads only need the L1 when it holds modified data
  assign inv_now  = (ev_kind_i == EV_SNP_RDX) || (ev_kind_i == EV_L2_EVCT);
  assign wb_now   = rd_incl_i && rd_stale_i;
  assign need_now = rd_incl_i && (inv_now || rd_stale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      line_q <= '0;
      need_q <= 1'b0;
      inv_q  <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (ev_valid_i) begin
          line_q <= ev_line_i;
          need_q <= need_now;
          inv_q  <= inv_now;
          wb_q   <= wb_now;
          st_q   <= need_now ? ST_REQ : ST_RESP;
        end
        ST_REQ:  st_q <= ack_i ? ST_RESP : ST_WAIT;
        ST_WAIT: if (ack_i) st_q <= ST_RESP;
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o        = (st_q == ST_IDLE);
  assign req_o          = (st_q == ST_REQ);
  assign req_line_o     = line_q;
  assign req_inv_o      = req_o && inv_q;
  assign req_wb_o       = req_o && wb_q;
  assign done_o         = (st_q == ST_RESP);
  assign done_l1_o      = done_o && need_q;
  assign done_wb_o      = done_o && need_q && wb_q;
  assign upd_en_o       = ack_i && ((st_q == ST_REQ) || (st_q == ST_WAIT));
  assign upd_line_o     = line_q;
  assign upd_clr_incl_o = inv_q;
endmodule

// File: rtl/inclusive_snoop_filter.sv
module inclusive_snoop_filter
  import sf_pkg::*;
#(
  parameter int unsigned SET_BITS = 6,
  parameter int unsigned WAY_BITS = 3,
  localparam int unsigned LW      = SET_BITS + WAY_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    l1_op_i,
  input  logic [LW-1:0] l1_line_i,
  input  logic          ev_valid_i,
  input  logic [1:0]    ev_kind_i,
  input  logic [LW-1:0] ev_line_i,
  output logic          ev_ready_o,
  output logic          l1_req_o,
  output logic [LW-1:0] l1_req_line_o,
  output logic          l1_req_inv_o,
  output logic          l1_req_wb_o,
  input  logic          l1_ack_i,
  output logic          done_o,
  output logic          done_l1_o,
  output logic          done_wb_o
);
  logic          rd_incl, rd_stale;
  logic          upd_en, upd_clr_incl;
  logic [LW-1:0] upd_line;

  sf_state_array #(.LW(LW)) u_array (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .op_i           (l1_op_e'(l1_op_i)),
    .op_line_i      (l1_line_i),
    .upd_en_i       (upd_en),
    .upd_line_i     (upd_line),
    .upd_clr_incl_i (upd_clr_incl),
    .rd_line_i      (ev_line_i),
    .rd_incl_o      (rd_incl),
    .rd_stale_o     (rd_stale)
  );

  sf_seq #(.LW(LW)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ev_valid_i     (ev_valid_i),
    .ev_kind_i      (ev_kind_e'(ev_kind_i)),
    .ev_line_i      (ev_line_i),
    .rd_incl_i      (rd_incl),
    .rd_stale_i     (rd_stale),
    .ack_i          (l1_ack_i),
    .ready_o        (ev_ready_o),
    .req_o          (l1_req_o),
    .req_line_o     (l1_req_line_o),
    .req_inv_o      (l1_req_inv_o),
    .req_wb_o       (l1_req_wb_o),
    .done_o         (done_o),
    .done_l1_o      (done_l1_o),
    .done_wb_o      (done_wb_o),
    .upd_en_o       (upd_en),
    .upd_line_o     (upd_line),
    .upd_clr_incl_o (upd_clr_incl)
  );
endmodule

// File: rtl/sf_checker.sv
module sf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ev_valid_i,
  input logic ev_ready_o,
  input logic l1_req_o,
  input logic l1_req_inv_o,
  input logic l1_req_wb_o,
  input logic l1_ack_i,
  input logic done_o,
  input logic done_l1_o,
  input logic done_wb_o
);
  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_req_o |-> $past(ev_valid_i && ev_ready_o)); // R4
  AST_REQ_HAS_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_req_o |-> (l1_req_inv_o || l1_req_wb_o)); // R5
  AST_DIRECT_DONE_NO_L1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(ev_valid_i && ev_ready_o)) |-> !done_l1_o); // R6
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_req_o |=> !l1_req_o); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_req_o || done_o) |-> !ev_ready_o); // R7
  AST_L1_DONE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_l1_o) |-> $past(l1_ack_i)); // R7
  AST_READY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ev_ready_o); // R7
  AST_WB_NEEDS_L1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_wb_o) |-> done_l1_o); // R8
endmodule

bind inclusive_snoop_filter sf_checker i_sf_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ev_valid_i   (ev_valid_i),
  .ev_ready_o   (ev_ready_o),
  .l1_req_o     (l1_req_o),
  .l1_req_inv_o (l1_req_inv_o),
  .l1_req_wb_o  (l1_req_wb_o),
  .l1_ack_i     (l1_ack_i),
  .done_o       (done_o),
  .done_l1_o    (done_l1_o),
  .done_wb_o    (done_wb_o)
);

// File: tb/test_inclusive_snoop_filter.sv
module test_inclusive_snoop_filter;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 2;
  localparam int WB = 1;
  localparam int LW = SB + WB;
  localparam int LINES = 1 << LW;
  localparam int WATCHDOG = 100000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    l1_op_i = 2'd0;
  logic [LW-1:0] l1_line_i = '0;
  logic          ev_valid_i = 1'b0;
  logic [1:0]    ev_kind_i = 2'd0;
  logic [LW-1:0] ev_line_i = '0;
  logic          ev_ready_o, l1_req_o, l1_req_inv_o, l1_req_wb_o;
  logic [LW-1:0] l1_req_line_o;
  logic          l1_ack_i = 1'b0;
  logic          done_o, done_l1_o, done_wb_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit m_incl [LINES];
  bit m_stale[LINES];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  inclusive_snoop_filter #(.SET_BITS(SB), .WAY_BITS(WB)) i_inclusive_snoop_filter (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic l1_note(input int op, input int line);
    @(negedge clk_i);
    l1_op_i = 2'(op); l1_line_i = LW'(line);
    @(negedge clk_i);
    l1_op_i = 2'd0;
    case (op)
      1: begin m_incl[line] = 1; m_stale[line] = 0; end
      2: begin m_incl[line] = 0; m_stale[line] = 0; end
      3: if (m_incl[line]) m_stale[line] = 1;
      default: ;
    endcase
  endtask

  task automatic event_run(input int kind, input int line, input int dly, input string tag);
    bit need, inv, wb;
    inv  = (kind != 0);
    wb   = m_incl[line] && m_stale[line];
    need = m_incl[line] && (inv || m_stale[line]);
    @(negedge clk_i);
    check(ev_ready_o == 1'b1, "R7 ready idle", ev_ready_o, 1);
    ev_valid_i = 1'b1; ev_kind_i = 2'(kind); ev_line_i = LW'(line);
    @(negedge clk_i);
    ev_valid_i = 1'b0;
    if (need) begin
      check(l1_req_o && !done_o, {tag, " req raised"}, l1_req_o, 1);
      check(l1_req_line_o == LW'(line), {tag, " req line"}, int'(l1_req_line_o), line);
      check(l1_req_inv_o == inv, {tag, " req inv"}, l1_req_inv_o, inv);
      check(l1_req_wb_o == wb, {tag, " req wb"}, l1_req_wb_o, wb);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk_i);
        check(!l1_req_o && !done_o && !ev_ready_o, "R7 waiting on ack", {l1_req_o, done_o}, 0);
      end
      l1_ack_i = 1'b1;
      @(negedge clk_i);
      l1_ack_i = 1'b0;
      check(done_o == 1'b1, "R7 done after ack", done_o, 1);
      check(done_l1_o == 1'b1, "R8 done_l1", done_l1_o, 1);
      check(done_wb_o == wb, "R8 done_wb", done_wb_o, wb);
      if (inv) begin m_incl[line] = 0; m_stale[line] = 0; end
      else m_stale[line] = 0;
    end else begin
      check(!l1_req_o && done_o, "R6 immediate done", {l1_req_o, done_o}, 1);
      check(!done_l1_o && !done_wb_o, "R6 no L1 flags", {done_l1_o, done_wb_o}, 0);
    end
    @(negedge clk_i);
    check(!done_o && ev_ready_o, "R7 back to idle", {done_o, ev_ready_o}, 1);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin m_incl[i] = 0; m_stale[i] = 0; end
    repeat (3) @(negedge clk_i);
    check(ev_ready_o && !l1_req_o && !done_o, "R1 reset outputs",
          {ev_ready_o, l1_req_o, done_o}, 4);
    rst_ni = 1'b1;
    // R1: every line starts without presence, so probes need no L1
    for (int l = 0; l < LINES; l++) event_run(1, l, 0, "R1 probe");
    // sweep: line x starting state x event kind, then probe with read-exclusive
    for (int l = 0; l < LINES; l++)
      for (int s = 0; s < 5; s++)
        for (int k = 0; k < 3; k++) begin
          l1_note(2, l);                      // R2 evict clears
          case (s)
            0: l1_note(3, l);                 // R3 write hit ignored without presence
            1: l1_note(1, l);                 // R2 fill
            2: begin l1_note(1, l); l1_note(3, l); end          // R3 stale
            3: begin l1_note(1, l); l1_note(3, l); l1_note(1, l); end // R2 refill clears stale
            default: begin l1_note(1, l); l1_note(3, l); l1_note(0, l); end // R2 no-op
          endcase
          event_run(k, l, (l + k + s) % 3, k == 0 ? "R5 read" : "R4 rdx/evict");
          event_run(1, l, 1, "R2 R4 probe");
        end
    // other lines untouched by a busy one: R2 isolation
    l1_note(1, 0); l1_note(3, 0);
    event_run(2, 1, 0, "R2 neighbour");
    event_run(0, 0, 2, "R5 read keeps presence");
    event_run(1, 0, 0, "R5 presence kept after flush");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule